// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block collects the event pulses of a two-wire serial bus controller and turns them into a single interrupt request and a small event code. Each pulse sets a sticky pending flag. A mask register selects which pending flags may raise the request. A vector register reports the most urgent pending, enabled event as a 3-bit code. The sources are, by index: lost arbitration, missing acknowledge, access ready, receive ready, transmit ready, stop seen, and addressed as target.

Reading the vector register also acknowledges the event it reports. An interrupt handler can therefore loop on vector reads until it gets zero, and it never has to touch the status register. The status register also carries two live levels from the protocol engine: receive shifter full and bus busy. Software can clear individual pending flags by writing ones to the status register.

The register port is a plain 16-bit read/write port. Reads are combinational in the cycle `reg_rd_i` is high. Write and read side effects take place at the next rising clock edge. There is no back-pressure: every access completes in one cycle.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, all pending flags and all mask bits are 0, the vector reads 0 and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k at the next clock edge, and the bit stays set until cleared. The bit order is 0 lost arbitration, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as target.
- R3: Writing the status register (offset 0x08) clears each pending bit 6:0 whose write-data bit is 1, and leaves bits written with 0 unchanged. An event arriving in the same cycle as the clear wins, so the bit stays set.
- R4: The mask register (offset 0x04) holds bits 6:0, with the same bit order as R2. It reads back what was written, and bits 15:7 read 0.
- R5: The vector register (offset 0x28) reads k+1 for the lowest index k that is both pending and enabled. It reads 0 when no such event exists, and bits 15:3 read 0.
- R6: A vector read that returns a nonzero code clears only that event's pending bit. A read that returns 0 changes nothing.
- R7: `irq_o` is high exactly when at least one pending bit has its mask bit set.
- R8: Status bit 11 follows `rsfull_i` and bit 12 follows `busy_i` in the same cycle. Writing those bits has no effect.
- R9: A pending bit whose mask bit is 0 remains visible in status, but it contributes neither to the vector nor to `irq_o`.
- R10: Reads at any other offset return 0. Writes to the vector offset or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Single-cycle event pulses, indexed as in R2 |
| rsfull_i | input | 1 | Live receive-shifter-full level |
| busy_i | input | 1 | Live bus-busy level |
| reg_addr_i | input | 8 | Byte offset of the register access |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid while `reg_rd_i` is high |
| irq_o | output | 1 | Interrupt request |

## Verification
Sparse random event bursts, mixed with random mask values, separate a priority encoder that picks the lowest index from one that picks the highest or the most recent. Directed drain loops with several sources pending show that each vector read removes exactly one flag, in ascending code order. Collisions between a clear and a new event in the same cycle, masked-only pending sets, writes to the live status bits and accesses to unmapped offsets each expose a different wrong rule: a clear that beats a set, a mask applied to the stored status, live bits stored as flags, or a loose address decode.

// File: rtl/ivu_pkg.sv
`timescale 1ns/1ps
package ivu_pkg;
  localparam int unsigned IVU_NUM_EVT = 7;
  localparam int unsigned IVU_DATA_W  = 16;
  localparam int unsigned IVU_ADDR_W  = 8;
  localparam int unsigned IVU_CODE_W  = $clog2(IVU_NUM_EVT + 1);

  typedef enum logic [IVU_ADDR_W-1:0] {
    OFS_MASK   = 8'h04,
    OFS_STATUS = 8'h08,
    OFS_VECTOR = 8'h28
  } ivu_ofs_e;
endpackage

// File: rtl/ivu_flags.sv
`timescale 1ns/1ps
module ivu_flags #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;
      else if (clr_i[g]) pend_o[g] <= 1'b0;
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_o[g]);

    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
  end
endmodule

// File: rtl/ivu_prio.sv
`timescale 1ns/1ps
module ivu_prio #(
  parameter int unsigned N  = 7,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [CW-1:0] code_o,
  output logic          hit_o
);
  always_comb begin
    code_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) code_o = CW'(k + 1);
    end
  end

  assign gnt_o = req_i & (~req_i + N'(1));
  assign hit_o = |req_i;

  always_comb begin
    if (hit_o) p_onehot_r5: assert ($onehot(gnt_o));
  end
endmodule

// File: rtl/ivu_regs.sv
`timescale 1ns/1ps
module ivu_regs
  import ivu_pkg::*;
#(
  parameter int unsigned N       = IVU_NUM_EVT,
  parameter int unsigned DW      = IVU_DATA_W,
  parameter int unsigned AW      = IVU_ADDR_W,
  parameter int unsigned CW      = IVU_CODE_W,
  parameter int unsigned RSF_BIT = 11,
  parameter int unsigned BSY_BIT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  gnt_i,
  input  logic [CW-1:0] code_i,
  input  logic          hit_i,
  input  logic          rsfull_i,
  input  logic          busy_i,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  clr_o,
  output logic          irq_o
);
  logic sel_mask, sel_stat, sel_vec;
  logic [DW-1:0] stat_word;

  assign sel_mask = (addr_i == AW'(OFS_MASK));
  assign sel_stat = (addr_i == AW'(OFS_STATUS));
  assign sel_vec  = (addr_i == AW'(OFS_VECTOR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mask_o <= '0;
    else if (wr_i && sel_mask) mask_o <= wdata_i[N-1:0];
  end

  always_comb begin
    stat_word          = '0;
    stat_word[N-1:0]   = pend_i;
    stat_word[RSF_BIT] = rsfull_i;
    stat_word[BSY_BIT] = busy_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel_mask)      rdata_o = DW'(mask_o);
      else if (sel_stat) rdata_o = stat_word;
      else if (sel_vec)  rdata_o = DW'(code_i);
    end
  end

  logic [N-1:0] w1c, vclr;
  assign w1c   = (wr_i && sel_stat) ? wdata_i[N-1:0] : '0;
  assign vclr  = (rd_i && sel_vec && hit_i) ? gnt_i : '0;
  assign clr_o = w1c | vclr;
  assign irq_o = |(pend_i & mask_o);

  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == hit_i);

  p_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |-> ((gnt_i & ~(pend_i & mask_o)) == '0));

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_mask) |=> (mask_o == $past(wdata_i[N-1:0])));
endmodule

// File: rtl/irq_vector_unit.sv
`timescale 1ns/1ps
module irq_vector_unit
  import ivu_pkg::*;
#(
  parameter int unsigned N  = IVU_NUM_EVT,
  parameter int unsigned DW = IVU_DATA_W,
  parameter int unsigned AW = IVU_ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic          rsfull_i,
  input  logic          busy_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [N-1:0]  pend, mask, clr, gnt;
  logic [CW-1:0] code;
  logic          hit;

  ivu_flags #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr), .pend_o(pend)
  );

  ivu_prio #(.N(N), .CW(CW)) u_prio (
    .req_i(pend & mask), .gnt_o(gnt), .code_o(code), .hit_o(hit)
  );

  ivu_regs #(.N(N), .DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .rd_i(reg_rd_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pend_i(pend), .gnt_i(gnt), .code_i(code), .hit_i(hit),
    .rsfull_i(rsfull_i), .busy_i(busy_i), .mask_o(mask), .clr_o(clr),
    .irq_o(irq_o)
  );

  p_rdclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == AW'(OFS_VECTOR) && hit && ((evt_i & gnt) == '0))
      |=> ((pend & $past(gnt)) == '0));
endmodule

// File: tb/test_irq_vector_unit.sv
`timescale 1ns/1ps
module test_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        rsfull = 1'b0, busy = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  logic [6:0] m_pend = '0, m_mask = '0;

  always #2.5 clk = ~clk;

  irq_vector_unit i_irq_vector_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rsfull_i(rsfull), .busy_i(busy),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [2:0] m_vec(logic [6:0] p, logic [6:0] m);
    logic [2:0] c = '0;
    for (int k = 6; k >= 0; k--) if (p[k] && m[k]) c = 3'(k + 1);
    return c;
  endfunction

  function automatic logic [15:0] m_read(logic [7:0] a);
    case (a)
      8'h04:   return {9'b0, m_mask};
      8'h08:   return {3'b0, busy, rsfull, 4'b0, m_pend};
      8'h28:   return {13'b0, m_vec(m_pend, m_mask)};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(string tag, logic [6:0] e, logic w, logic r,
                       logic [7:0] a, logic [15:0] d);
    logic [2:0] v;
    @(negedge clk);
    evt = e; wr = w; rd = r; addr = a; wdata = d;
    #1;
    if (r) check(tag, rdata, m_read(a));
    v = m_vec(m_pend, m_mask);
    @(posedge clk);
    if (r && a == 8'h28 && v != 0) m_pend[v-1] = 1'b0;
    if (w && a == 8'h08) m_pend = m_pend & ~d[6:0];
    if (w && a == 8'h04) m_mask = d[6:0];
    m_pend = m_pend | e;
    #1;
    evt = '0; wr = 1'b0; rd = 1'b0;
    @(negedge clk);
    check("R7 irq", {15'b0, irq}, {15'b0, |(m_pend & m_mask)});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    logic [7:0] alist [4];
    seed = $urandom(32'd4711);
    alist[0] = 8'h04; alist[1] = 8'h08; alist[2] = 8'h28; alist[3] = 8'h10;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1 irq", {15'b0, irq}, 16'h0);
    cycle("R1 status", 0, 0, 1, 8'h08, 0);
    cycle("R1 mask", 0, 0, 1, 8'h04, 0);
    cycle("R1 vector", 0, 0, 1, 8'h28, 0);
    // R2/R6: drain in ascending code order
    cycle("R4 mask write", 0, 1, 0, 8'h04, 16'hffff);
    cycle("R4 mask read", 0, 0, 1, 8'h04, 0);
    cycle("R2 events", 7'b0110001, 0, 0, 8'h00, 0);
    cycle("R2 status", 0, 0, 1, 8'h08, 0);
    for (int i = 0; i < 4; i++) cycle("R6 drain", 0, 0, 1, 8'h28, 0);
    cycle("R6 status empty", 0, 0, 1, 8'h08, 0);
    // R9: masked pending
    cycle("R9 mask", 0, 1, 0, 8'h04, 16'h0004);
    cycle("R9 event", 7'b0000010, 0, 0, 8'h00, 0);
    cycle("R9 vector", 0, 0, 1, 8'h28, 0);
    cycle("R9 status", 0, 0, 1, 8'h08, 0);
    // R3: clear with concurrent event
    cycle("R3 set", 7'b0000100, 0, 0, 8'h00, 0);
    cycle("R3 clear+event", 7'b0000100, 1, 0, 8'h08, 16'h0004);
    cycle("R3 still set", 0, 0, 1, 8'h08, 0);
    cycle("R3 clear zeros", 0, 1, 0, 8'h08, 16'h0000);
    cycle("R3 unchanged", 0, 0, 1, 8'h08, 0);
    cycle("R3 clear", 0, 1, 0, 8'h08, 16'h0006);
    cycle("R3 cleared", 0, 0, 1, 8'h08, 0);
    // R8: live levels
    busy = 1'b1; rsfull = 1'b1;
    cycle("R8 live", 0, 0, 1, 8'h08, 0);
    cycle("R8 write", 0, 1, 0, 8'h08, 16'h1800);
    cycle("R8 after write", 0, 0, 1, 8'h08, 0);
    busy = 1'b0;
    cycle("R8 busy low", 0, 0, 1, 8'h08, 0);
    rsfull = 1'b0;
    // R10: unmapped / vector writes
    cycle("R10 set", 7'b1000000, 1, 0, 8'h04, 16'h0040);
    cycle("R10 vec write", 0, 1, 0, 8'h28, 16'hffff);
    cycle("R10 odd write", 0, 1, 0, 8'h0c, 16'hffff);
    cycle("R10 odd read", 0, 0, 1, 8'h0c, 0);
    cycle("R10 vector kept", 0, 0, 1, 8'h28, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [6:0] e;
      logic [1:0] op;
      logic [7:0] a;
      e  = 7'($urandom & $urandom & $urandom);
      op = 2'($urandom);
      a  = alist[$urandom % 4];
      busy = 1'($urandom); rsfull = 1'($urandom);
      cycle("R5 random", e, op == 2'd1, op[1], a, 16'($urandom));
    end
    finish_run();
  end
endmodule